// File: doc/BRIEF.md
# Byte-wide Flash Window Bridge

This block connects a 32-bit host memory port to an external byte-wide parallel flash or boot ROM of up to 128 KB. The block compares each host request with two base addresses. One selects the flash window. The other selects an expansion-ROM window, which has its own enable. When a request hits a window and follows the size rules, the block runs one or two byte cycles on the flash pins. It then returns the read data and a one-cycle ready pulse.

A read may fetch a single byte or a 16-bit halfword. A halfword is built from two back-to-back byte cycles at consecutive flash addresses, with the first byte in the lower lane. A write carries exactly one byte and is passed to the flash without change, so any unlock or program sequence is left to software. A request that misses both windows, or breaks a size rule, ends with ready and an error flag, and no flash strobe is driven. The byte-cycle length is a parameter. An elaboration check keeps the slowest access inside a 16-wait-state budget.

Top module: `flash_window_bridge`

## Requirements
- R1: A request hits the flash window when host address bits [31:17] equal `cfg_flash_base`. The flash offset is address bits [16:2] followed by the 2-bit index of the lowest enabled byte lane. For a halfword read, that lane index is 0 when `req_be`=4'b0011 and 2 when `req_be`=4'b1100. Host address bits [1:0] are ignored.
- R2: When `cfg_rom_en` is 1, a request also hits when address bits [31:17] equal `cfg_rom_base`, and it is served exactly like a flash-window hit. When `cfg_rom_en` is 0, a request that matches only the ROM base is treated as a miss, and the flash window keeps working.
- R3: A request that misses both windows gets `rsp_ready`=1 and `rsp_error`=1 in the cycle that starts one clock edge after the edge that accepts it. `fl_ce_n`, `fl_oe_n` and `fl_we_n` stay high throughout.
- R4: A read with exactly one bit of `req_be` set runs a single byte cycle. The byte returns in the lane of that enable, and all other bits of `rsp_rdata` are 0.
- R5: A read with `req_be`=4'b0011 or 4'b1100 runs two consecutive byte cycles, first at offset A and then at A+1. The byte from A lands in the lower of the two enabled lanes and the byte from A+1 in the upper lane. All other bits are 0.
- R6: A read with any other `req_be` value, including 4'b0000, is rejected: ready and error are returned one edge after acceptance, and no strobe is driven.
- R7: A write with exactly one enable set runs one byte cycle of CYCLE_CLKS clocks with `fl_ce_n` low and `fl_dq_oe` high. `fl_dq_out` carries the write-data byte of the enabled lane. `fl_we_n` is low only from the second through the next-to-last clock of the cycle.
- R8: A write with zero, two or more enables set is rejected with ready and error, and no strobe is driven. The flash contents stay unchanged.
- R9: `fl_oe_n` is low for every clock of a read byte cycle and never low at the same time as `fl_we_n`. Address and write data are held for one clock before `fl_we_n` falls and for one clock after it rises.
- R10: `rsp_ready` is a single-cycle pulse. For a legal access it rises CYCLE_CLKS edges after the accepting edge for a single byte, and 2*CYCLE_CLKS edges after for a halfword. It never exceeds 16 waits.
- R11: After reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, and `fl_dq_oe`, `rsp_ready` and `rsp_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until the ready pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_be | input | 4 | Host byte enables |
| req_wdata | input | 32 | Host write data |
| cfg_flash_base | input | 15 | Flash window base, compared with address [31:17] |
| cfg_rom_base | input | 15 | Expansion-ROM window base, compared with address [31:17] |
| cfg_rom_en | input | 1 | Enables the expansion-ROM window |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Request rejected; valid with rsp_ready |
| rsp_rdata | output | 32 | Read data placed in its byte lanes; valid with rsp_ready |
| fl_addr | output | 17 | Flash byte address |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The bench builds the bridge with CYCLE_CLKS set to 4 instead of the default 3. This gives a two-clock write-enable pulse, so the bench can check both edges of the setup and hold margins. It also brings a halfword read to eight edges, inside the 16-wait budget. Base addresses and the ROM enable are driven from the bench. This exercises the ROM window, the ROM window disabled, misses, and offsets at the very top of the 128 KB space.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } fwb_state_e;

  typedef struct packed {
    logic        err;
    logic        write;
    logic        word;
    logic [1:0]  lane;
    logic [16:0] offs;
    logic [7:0]  wbyte;
  } fwb_req_t;

endpackage

// File: rtl/fwb_decode.sv
module fwb_decode
  import fwb_pkg::*;
#(
  parameter int HOST_AW = 32,
  parameter int FL_AW   = 17
) (
  input  logic                     write,
  input  logic [HOST_AW-1:0]       addr,
  input  logic [3:0]               be,
  input  logic [31:0]              wdata,
  input  logic [HOST_AW-FL_AW-1:0] flash_base,
  input  logic [HOST_AW-FL_AW-1:0] rom_base,
  input  logic                     rom_en,
  output fwb_req_t                 dec
);

  localparam int BASE_W = HOST_AW - FL_AW;

  logic [BASE_W-1:0] tag;
  logic              hit_flash;
  logic              hit_rom;
  logic              be_single;
  logic              be_half;
  logic              size_ok;
  logic [1:0]        lane;

  assign tag       = addr[HOST_AW-1:FL_AW];
  assign hit_flash = (tag == flash_base);
  assign hit_rom   = rom_en && (tag == rom_base);
  assign be_single = (be == 4'b0001) || (be == 4'b0010) ||
                     (be == 4'b0100) || (be == 4'b1000);
  assign be_half   = (be == 4'b0011) || (be == 4'b1100);
  assign size_ok   = write ? be_single : (be_single || be_half);

  always_comb begin
    if (be[0])      lane = 2'd0;
    else if (be[1]) lane = 2'd1;
    else if (be[2]) lane = 2'd2;
    else            lane = 2'd3;
  end

  always_comb begin
    dec       = '0;
    dec.err   = !(hit_flash || hit_rom) || !size_ok;
    dec.write = write;
    dec.word  = !write && be_half;
    dec.lane  = lane;
    dec.offs  = {addr[FL_AW-1:2], lane};
    dec.wbyte = wdata[lane*8 +: 8];
  end

endmodule

// File: rtl/fwb_strobe.sv
module fwb_strobe #(
  parameter int CYCLE_CLKS = 3,
  parameter int FL_AW      = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_in,
  input  logic [FL_AW-1:0] addr_in,
  input  logic [7:0]       data_in,
  output logic             busy,
  output logic             done,
  output logic [FL_AW-1:0] fl_addr,
  output logic [7:0]       fl_dq_out,
  output logic             fl_dq_oe,
  output logic             fl_ce_n,
  output logic             fl_oe_n,
  output logic             fl_we_n
);

  localparam int CNT_W = $clog2(CYCLE_CLKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLE_CLKS - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic [FL_AW-1:0] addr_q, addr_d;
  logic [7:0]       data_q, data_d;
  logic             load_en;

  assign done    = busy_q && (cnt_q == CNT_LAST);
  assign load_en = start;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_comb begin
    wr_d   = wr_q;
    addr_d = addr_q;
    data_d = data_q;
    if (load_en) begin
      wr_d   = wr_in;
      addr_d = addr_in;
      data_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy      = busy_q;
  assign fl_addr   = addr_q;
  assign fl_dq_out = data_q;
  assign fl_dq_oe  = busy_q && wr_q;
  assign fl_ce_n   = !busy_q;
  assign fl_oe_n   = !(busy_q && !wr_q);
  assign fl_we_n   = !(busy_q && wr_q && (cnt_q != '0) && (cnt_q != CNT_LAST));

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_oe_n && !fl_we_n)); // R9

  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> $stable(fl_addr) && $stable(fl_dq_out) && !fl_ce_n); // R9

  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> $stable(fl_addr) && $stable(fl_dq_out) && !fl_ce_n); // R9

  AST_WE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_dq_oe); // R7

endmodule

// File: rtl/fwb_assemble.sv
module fwb_assemble (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cap,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  output logic [31:0] rdata
);

  logic [7:0] byte_q [4];
  logic [7:0] byte_d [4];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    always_comb begin
      byte_d[g] = byte_q[g];
      if (clr)
        byte_d[g] = 8'h00;
      else if (cap && (lane == 2'(g)))
        byte_d[g] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[g] <= 8'h00;
      else        byte_q[g] <= byte_d[g];
    end

    assign rdata[g*8 +: 8] = byte_q[g];
  end

endmodule

// File: rtl/flash_window_bridge.sv
module flash_window_bridge
  import fwb_pkg::*;
#(
  parameter int CYCLE_CLKS = 3,
  parameter int MAX_WAIT   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  input  logic [14:0] cfg_flash_base,
  input  logic [14:0] cfg_rom_base,
  input  logic        cfg_rom_en,
  output logic        rsp_ready,
  output logic        rsp_error,
  output logic [31:0] rsp_rdata,
  output logic [16:0] fl_addr,
  output logic [7:0]  fl_dq_out,
  output logic        fl_dq_oe,
  input  logic [7:0]  fl_dq_in,
  output logic        fl_ce_n,
  output logic        fl_oe_n,
  output logic        fl_we_n
);

  localparam int HOST_AW = 32;
  localparam int FL_AW   = 17;
  localparam int LAT_W   = $clog2(2 * CYCLE_CLKS + 4);

  if (CYCLE_CLKS < 3 || (2 * CYCLE_CLKS + 2) > MAX_WAIT) begin : g_bad_cycle
    $error("CYCLE_CLKS out of range for the wait budget");
  end

  fwb_state_e       state_q, state_d;
  fwb_req_t         dec;
  fwb_req_t         req_q, req_d;
  logic             second_q, second_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             accept;
  logic             st_start;
  logic             st_wr;
  logic [FL_AW-1:0] st_addr;
  logic [7:0]       st_data;
  logic             st_busy;
  logic             st_done;
  logic             cap;
  logic [1:0]       cap_lane;

  fwb_decode #(.HOST_AW(HOST_AW), .FL_AW(FL_AW)) u_decode (
    .write      (req_write),
    .addr       (req_addr),
    .be         (req_be),
    .wdata      (req_wdata),
    .flash_base (cfg_flash_base),
    .rom_base   (cfg_rom_base),
    .rom_en     (cfg_rom_en),
    .dec        (dec)
  );

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    req_d    = req_q;
    second_d = second_q;
    st_start = 1'b0;
    st_wr    = req_q.write;
    st_addr  = req_q.offs + 1'b1;
    st_data  = req_q.wbyte;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          req_d    = dec;
          second_d = 1'b0;
          if (dec.err) begin
            state_d = ST_RESP;
          end else begin
            state_d  = ST_XFER;
            st_start = 1'b1;
            st_wr    = dec.write;
            st_addr  = dec.offs;
            st_data  = dec.wbyte;
          end
        end
      end
      ST_XFER: begin
        if (st_done) begin
          if (req_q.word && !second_q) begin
            second_d = 1'b1;
            st_start = 1'b1;
          end else begin
            state_d = ST_RESP;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    lat_d = lat_q;
    if (accept)
      lat_d = '0;
    else if (state_q != ST_IDLE)
      lat_d = lat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      req_q    <= '0;
      second_q <= 1'b0;
      lat_q    <= '0;
    end else begin
      state_q  <= state_d;
      req_q    <= req_d;
      second_q <= second_d;
      lat_q    <= lat_d;
    end
  end

  fwb_strobe #(.CYCLE_CLKS(CYCLE_CLKS), .FL_AW(FL_AW)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (st_start),
    .wr_in     (st_wr),
    .addr_in   (st_addr),
    .data_in   (st_data),
    .busy      (st_busy),
    .done      (st_done),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n)
  );

  assign cap      = (state_q == ST_XFER) && st_done && !req_q.write;
  assign cap_lane = req_q.lane + {1'b0, second_q};

  fwb_assemble u_assemble (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .cap   (cap),
    .lane  (cap_lane),
    .din   (fl_dq_in),
    .rdata (rsp_rdata)
  );

  assign rsp_ready = (state_q == ST_RESP);
  assign rsp_error = (state_q == ST_RESP) && req_q.err;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready); // R10

  AST_WAIT_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (int'(lat_q) <= MAX_WAIT)); // R10

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> fl_ce_n && $past(fl_ce_n)); // R3

  AST_XFER_HAS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER) |-> !fl_ce_n); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe); // R11

endmodule

// File: tb/flash_window_bridge_tb.sv
module flash_window_bridge_tb;

  localparam int CYC = 4;
  localparam logic [14:0] FL_BASE  = 15'h7FF0;
  localparam logic [14:0] ROM_BASE = 15'h0123;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        cfg_rom_en;
  logic        rsp_ready, rsp_error;
  logic [31:0] rsp_rdata;
  logic [16:0] fl_addr;
  logic [7:0]  fl_dq_out, fl_dq_in;
  logic        fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [int];

  always #2.5 clk = ~clk;

  flash_window_bridge #(.CYCLE_CLKS(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .cfg_flash_base(FL_BASE), .cfg_rom_base(ROM_BASE), .cfg_rom_en(cfg_rom_en),
    .rsp_ready(rsp_ready), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  function automatic logic [7:0] rd_mem(input logic [16:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return (a[7:0] ^ {a[15:8]}) + 8'h5A + {7'd0, a[16]};
  endfunction

  assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? rd_mem(fl_addr) : 8'h00;

  always @(posedge fl_we_n) begin
    if (!fl_ce_n && fl_dq_oe) mem[int'(fl_addr)] = fl_dq_out;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(input string tag, input bit wr, input logic [31:0] a,
                        input logic [3:0] be, input logic [31:0] wd);
    bit hit, legal, err, half;
    int nbytes, lane;
    logic [16:0] offs;
    logic [31:0] exp_rd;
    hit   = (a[31:17] == FL_BASE) || (cfg_rom_en && a[31:17] == ROM_BASE);
    half  = (be == 4'b0011) || (be == 4'b1100);
    legal = wr ? ($countones(be) == 1) : (($countones(be) == 1) || half);
    err   = !hit || !legal;
    nbytes = (!wr && half) ? 2 : 1;
    lane  = be[0] ? 0 : be[1] ? 1 : be[2] ? 2 : 3;
    offs  = {a[16:2], 2'(lane)};
    exp_rd = '0;
    if (!wr && !err)
      for (int b = 0; b < nbytes; b++) exp_rd[(lane+b)*8 +: 8] = rd_mem(offs + 17'(b));
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    @(posedge clk);
    if (!err) begin
      for (int b = 0; b < nbytes; b++) begin
        for (int c = 0; c < CYC; c++) begin
          @(negedge clk);
          chk({tag, " ce_n"}, 32'(fl_ce_n), 32'd0);
          chk({tag, " oe_n R9"}, 32'(fl_oe_n), 32'(wr));
          chk({tag, " we_n R7"}, 32'(fl_we_n), 32'(!(wr && c != 0 && c != CYC - 1)));
          chk({tag, " addr R1"}, 32'(fl_addr), 32'(offs + 17'(b)));
          chk({tag, " dq_oe"}, 32'(fl_dq_oe), 32'(wr));
          if (wr) chk({tag, " wdata R7"}, 32'(fl_dq_out), 32'(wd[lane*8 +: 8]));
          chk({tag, " early ready R10"}, 32'(rsp_ready), 32'd0);
        end
      end
    end
    @(negedge clk);
    chk({tag, " ready R10"}, 32'(rsp_ready), 32'd1);
    chk({tag, " error R3"}, 32'(rsp_error), 32'(err));
    chk({tag, " no strobe R6"}, 32'({fl_ce_n, fl_oe_n, fl_we_n}), 32'd7);
    if (!wr && !err) chk({tag, " rdata R5"}, rsp_rdata, exp_rd);
    req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " pulse R10"}, 32'(rsp_ready), 32'd0);
    chk({tag, " idle ce"}, 32'(fl_ce_n), 32'd1);
  endtask

  task automatic expect_mem(input string tag, input logic [16:0] a, input logic [7:0] v);
    chk(tag, 32'(rd_mem(a)), 32'(v));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_be = '0; req_wdata = '0; cfg_rom_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 ce_n", 32'(fl_ce_n), 32'd1);
    chk("R11 oe_n", 32'(fl_oe_n), 32'd1);
    chk("R11 we_n", 32'(fl_we_n), 32'd1);
    chk("R11 ready/err/oe", 32'({rsp_ready, rsp_error, fl_dq_oe}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int l = 0; l < 4; l++)
      access("R4 byte read", 1'b0, {FL_BASE, 17'h00104}, 4'(1 << l), '0);
    access("R5 half low", 1'b0, {FL_BASE, 17'h00200}, 4'b0011, '0);
    access("R5 half high", 1'b0, {FL_BASE, 17'h00203}, 4'b1100, '0);
    access("R1 top byte", 1'b0, {FL_BASE, 17'h1FFFC}, 4'b1000, '0);
    access("R5 top half", 1'b0, {FL_BASE, 17'h1FFFC}, 4'b1100, '0);

    access("R7 write", 1'b1, {FL_BASE, 17'h00400}, 4'b0100, 32'h11A5_2233);
    expect_mem("R7 stored", 17'h00402, 8'hA5);
    access("R7 readback", 1'b0, {FL_BASE, 17'h00400}, 4'b1100, '0);

    access("R8 two-byte write", 1'b1, {FL_BASE, 17'h00500}, 4'b0011, 32'h0000_BEEF);
    expect_mem("R8 untouched", 17'h00500, rd_mem(17'h00500));
    access("R8 readback", 1'b0, {FL_BASE, 17'h00500}, 4'b0011, '0);
    access("R8 no-enable write", 1'b1, {FL_BASE, 17'h00600}, 4'b0000, 32'hFFFF_FFFF);

    access("R6 three-lane read", 1'b0, {FL_BASE, 17'h00010}, 4'b0111, '0);
    access("R6 empty read", 1'b0, {FL_BASE, 17'h00010}, 4'b0000, '0);
    access("R6 mid half read", 1'b0, {FL_BASE, 17'h00010}, 4'b0110, '0);

    access("R2 rom read", 1'b0, {ROM_BASE, 17'h00020}, 4'b0011, '0);
    cfg_rom_en = 1'b0;
    access("R2 rom disabled", 1'b0, {ROM_BASE, 17'h00020}, 4'b0011, '0);
    access("R2 flash still on", 1'b0, {FL_BASE, 17'h00020}, 4'b0001, '0);
    cfg_rom_en = 1'b1;
    access("R3 miss", 1'b0, {15'h0456, 17'h00000}, 4'b0001, '0);
    access("R3 miss write", 1'b1, {15'h7FF1, 17'h00000}, 4'b0001, 32'h55);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule